// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen sources and presents a single interrupt line to a processor. Internally it holds two identical eight-line controller units. The first acts as the master and faces the processor. The second acts as the slave, and its interrupt output is fed into one reserved request input of the master (line 2). Each unit latches its requests and applies a per-line mask. Within each unit, priority is fixed: the lowest index wins. An in-service record lets a higher-priority request preempt one already being serviced, while requests of equal or lower priority wait.

The processor answers the interrupt with two acknowledge pulses. The first pulse freezes the winning line, marks it in service and drops its request. The second pulse places a vector byte on the data bus. The vector is the upper five bits of a programmable base followed by the three-bit line index. When the master's winner is the link line, the master selects the slave through an internal cascade identifier, and only the slave drives the vector. A request on the external legacy line 2 is steered to slave input 1, so it is serviced as line 9.

A small write port sets the two masks and the two vector bases, and issues end-of-interrupt commands to either unit. An end-of-interrupt command retires the highest-priority in-service line of that unit.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, int_out and vec_oe are low, both masks are clear and both vector bases are zero.
- R2: A request held high for one clock stays latched; among pending unmasked master lines the lowest index wins, and int_out rises when a winner outranks every in-service line.
- R3: Acknowledge is two inta pulses. The first marks the winner in service and clears its request, with vec_oe low. The second drives vec_out = {base[7:3], index} with vec_oe high during that pulse only.
- R4: A pending line of higher priority than the highest in-service line raises int_out; a line of equal or lower priority keeps int_out low until end-of-interrupt.
- R5: A write to address 4 (master) or 5 (slave) clears the lowest-index set in-service bit of that unit.
- R6: A masked line never raises int_out, but its request stays latched and raises int_out once the mask bit is cleared.
- R7: Input irq_in[8+k] is slave line k. When the master acknowledges its link line 2, the slave acknowledges its own winner and drives {slave_base[7:3], k}, and the master drives nothing.
- R8: irq_in[2] is serviced through slave line 1 and yields the same vector as irq_in[9].
- R9: An acknowledge with nothing pending returns index 7 and marks no line in service.
- R10: Register writes use wr_addr 0 for the master mask, 1 for the slave mask, 2 for the master base and 3 for the slave base; mask bit i masks line i and base bits [2:0] are ignored.
- R11: At most one unit drives the vector bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; bit 2 is steered to slave line 1, bits 15:8 are slave lines 7:0 |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| vec_out | output | 8 | Vector byte, zero when not driven |
| vec_oe | output | 1 | Vector bus drive enable |

## Verification
The bench builds the block with its default parameters: the link on master line 2 and the legacy line steered to slave line 1. These values give a fixed mapping from every external line to a vector. With that mapping, the bench can predict every vector for a single line, for competing lines within a unit, and for a slave line competing against a master line of lower priority across the link. The defaults also let the bench drive the nested sequences on both units: preemption, blocking by equal priority, and end-of-interrupt choosing the highest in-service line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;
    localparam int ADDR_W = 3;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_MMASK = 3'd0,
        REG_SMASK = 3'd1,
        REG_MBASE = 3'd2,
        REG_SBASE = 3'd3,
        REG_MEOI  = 3'd4,
        REG_SEOI  = 3'd5
    } reg_sel_e;

    // lowest set index has the highest priority
    function automatic pick_t pick_top(input line_vec_t v);
        pick_t p;
        p.valid = 1'b0;
        p.idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic line_vec_t idx_onehot(input idx_t i);
        return line_vec_t'(1) << i;
    endfunction

    function automatic logic [VEC_W-1:0] make_vector(input logic [BASE_W-1:0] base, input idx_t i);
        return {base, i};
    endfunction
endpackage

// File: rtl/irqc_latch.sv
module irqc_latch
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req,
    input  line_vec_t clr,
    output line_vec_t irr
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst)
                    held_q <= 1'b0;
                else if (clr[g])
                    held_q <= 1'b0;
                else if (req[g])
                    held_q <= 1'b1;
            end
            assign irr[g] = held_q;
        end
    endgenerate
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
    import irqc_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t mask,
    input  line_vec_t isr,
    output pick_t     win,
    output pick_t     isr_top,
    output logic      intr
);
    line_vec_t pend;

    always_comb begin
        pend    = irr & ~mask;
        win     = pick_top(pend);
        isr_top = pick_top(isr);
        intr    = win.valid && (!isr_top.valid || (win.idx < isr_top.idx));
    end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_vec_t         req,
    input  line_vec_t         mask,
    input  logic [BASE_W-1:0] base,
    input  logic              eoi,
    input  logic              inta,
    input  logic              sel,
    input  logic              defer,
    output logic              intr,
    output idx_t              ack_idx,
    output logic              ack_real,
    output logic [VEC_W-1:0]  vec,
    output logic              vec_oe,
    output line_vec_t         isr
);
    localparam idx_t SPUR_IDX = idx_t'(LINES - 1);

    line_vec_t irr;
    line_vec_t irr_clr;
    line_vec_t isr_n;
    pick_t     win;
    pick_t     isr_top;
    pick_t     frz_q;
    logic      phase_q;
    logic      ack_go;
    logic      first;
    logic      second;

    irqc_latch u_latch (
        .clk (clk),
        .rst (rst),
        .req (req),
        .clr (irr_clr),
        .irr (irr)
    );

    irqc_resolve u_res (
        .irr     (irr),
        .mask    (mask),
        .isr     (isr),
        .win     (win),
        .isr_top (isr_top),
        .intr    (intr)
    );

    always_comb begin
        ack_go  = inta & sel;
        first   = ack_go & ~phase_q;
        second  = ack_go & phase_q;
        irr_clr = (first && win.valid) ? idx_onehot(win.idx) : '0;

        isr_n = isr;
        if (eoi && isr_top.valid)
            isr_n[isr_top.idx] = 1'b0;
        if (first && win.valid)
            isr_n[win.idx] = 1'b1;

        ack_real = phase_q ? frz_q.valid : win.valid;
        ack_idx  = phase_q ? frz_q.idx : (win.valid ? win.idx : SPUR_IDX);

        vec_oe = second & ~defer;
        vec    = vec_oe ? make_vector(base, frz_q.idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            phase_q <= 1'b0;
            frz_q   <= '0;
        end else begin
            isr <= isr_n;
            if (first) begin
                phase_q     <= 1'b1;
                frz_q.valid <= win.valid;
                frz_q.idx   <= win.valid ? win.idx : SPUR_IDX;
            end else if (second) begin
                phase_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int CASC_LINE    = 2,
    parameter int REDIRECT_IDX = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*LINES-1:0] irq_in,
    output logic               int_out,
    input  logic               inta,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [VEC_W-1:0]   wr_data,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe
);
    localparam idx_t CASC_IDX = idx_t'(CASC_LINE);

    line_vec_t         m_mask, s_mask;
    logic [BASE_W-1:0] m_base, s_base;
    line_vec_t         m_req, s_req;
    line_vec_t         m_isr, s_isr;
    logic              m_eoi, s_eoi;
    logic              m_intr, s_intr;
    idx_t              m_ack_idx, s_ack_idx;
    logic              m_ack_real, s_ack_real;
    logic [VEC_W-1:0]  m_vec, s_vec;
    logic              m_vec_oe, s_vec_oe;
    logic              m_link, casc_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_mask <= '0;
            s_mask <= '0;
            m_base <= '0;
            s_base <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_MMASK: m_mask <= wr_data;
                REG_SMASK: s_mask <= wr_data;
                REG_MBASE: m_base <= wr_data[VEC_W-1:IDX_W];
                REG_SBASE: s_base <= wr_data[VEC_W-1:IDX_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        m_eoi = wr_en && (reg_sel_e'(wr_addr) == REG_MEOI);
        s_eoi = wr_en && (reg_sel_e'(wr_addr) == REG_SEOI);

        m_req            = irq_in[LINES-1:0];
        m_req[CASC_LINE] = s_intr;

        s_req               = irq_in[2*LINES-1:LINES];
        s_req[REDIRECT_IDX] = s_req[REDIRECT_IDX] | irq_in[CASC_LINE];

        m_link   = m_ack_real && (m_ack_idx == CASC_IDX);
        casc_sel = inta && m_link;
    end

    irqc_unit u_master (
        .clk      (clk),
        .rst      (rst),
        .req      (m_req),
        .mask     (m_mask),
        .base     (m_base),
        .eoi      (m_eoi),
        .inta     (inta),
        .sel      (1'b1),
        .defer    (m_link),
        .intr     (m_intr),
        .ack_idx  (m_ack_idx),
        .ack_real (m_ack_real),
        .vec      (m_vec),
        .vec_oe   (m_vec_oe),
        .isr      (m_isr)
    );

    irqc_unit u_slave (
        .clk      (clk),
        .rst      (rst),
        .req      (s_req),
        .mask     (s_mask),
        .base     (s_base),
        .eoi      (s_eoi),
        .inta     (inta),
        .sel      (casc_sel),
        .defer    (1'b0),
        .intr     (s_intr),
        .ack_idx  (s_ack_idx),
        .ack_real (s_ack_real),
        .vec      (s_vec),
        .vec_oe   (s_vec_oe),
        .isr      (s_isr)
    );

    assign int_out = m_intr;
    assign vec_out = m_vec | s_vec;
    assign vec_oe  = m_vec_oe | s_vec_oe;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              inta,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              int_out,
    input logic              vec_oe,
    input logic [VEC_W-1:0]  vec_out,
    input logic              m_vec_oe,
    input logic              s_vec_oe,
    input idx_t              m_ack_idx,
    input idx_t              s_ack_idx,
    input logic              m_ack_real,
    input logic              s_ack_real,
    input line_vec_t         m_isr,
    input line_vec_t         s_isr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!int_out && !vec_oe));

    // R11
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({m_vec_oe, s_vec_oe}));

    // R3
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> inta);

    // R3
    vec_idx_chk: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> (vec_out[IDX_W-1:0] == (m_vec_oe ? m_ack_idx : s_ack_idx)));

    // R9
    spur_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_oe && !(m_vec_oe ? m_ack_real : s_ack_real)) |-> (vec_out[IDX_W-1:0] == idx_t'(LINES - 1)));

    // R5
    eoi_master_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(4) && !inta && m_isr != '0)
            |=> ($countones(m_isr) + 1 == $countones($past(m_isr))));

    // R5
    eoi_slave_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(5) && !inta && s_isr != '0)
            |=> ($countones(s_isr) + 1 == $countones($past(s_isr))));
endmodule

bind irqc_cascade irqc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .inta       (inta),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .int_out    (int_out),
    .vec_oe     (vec_oe),
    .vec_out    (vec_out),
    .m_vec_oe   (m_vec_oe),
    .s_vec_oe   (s_vec_oe),
    .m_ack_idx  (m_ack_idx),
    .s_ack_idx  (s_ack_idx),
    .m_ack_real (m_ack_real),
    .s_ack_real (s_ack_real),
    .m_isr      (m_isr),
    .s_isr      (s_isr)
);

// File: tb/sim_irqc_cascade.sv
module sim_irqc_cascade;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic        int_out;
    logic        inta = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  vec_out;
    logic        vec_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqc_cascade u0 (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .int_out (int_out),
        .inta    (inta),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .vec_out (vec_out),
        .vec_oe  (vec_oe)
    );

    typedef struct packed {
        logic [15:0] irq;
        logic [7:0]  mm;
        logic [7:0]  sm;
        logic        en;
        logic [7:0]  vec;
    } row_t;

    // master base 0x20, slave base 0x70
    localparam row_t TBL [9] = '{
        '{16'h0020, 8'h00, 8'h00, 1'b1, 8'h25},  // R2 single line
        '{16'h0028, 8'h00, 8'h00, 1'b1, 8'h23},  // R2 lower index wins
        '{16'h0081, 8'h00, 8'h00, 1'b1, 8'h20},  // R2 line 0 over line 7
        '{16'h0400, 8'h00, 8'h00, 1'b1, 8'h72},  // R7 slave line 2
        '{16'h0404, 8'h00, 8'h00, 1'b1, 8'h71},  // R8 legacy beats line 10
        '{16'h0200, 8'h00, 8'h00, 1'b1, 8'h71},  // R7 line 9
        '{16'h0020, 8'h20, 8'h00, 1'b0, 8'h00},  // R6 masked master line
        '{16'h8010, 8'h00, 8'h00, 1'b1, 8'h77},  // R7 link outranks line 4
        '{16'h0808, 8'h00, 8'h08, 1'b1, 8'h23}   // R10 slave mask bit 3
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic pulse_irq(input logic [15:0] p);
        @(negedge clk);
        irq_in = p;
        @(negedge clk);
        irq_in = '0;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic oe2, output logic oe1);
        @(negedge clk);
        inta = 1'b1;
        #1 oe1 = vec_oe;
        @(negedge clk);
        inta = 1'b0;
        @(negedge clk);
        inta = 1'b1;
        #1 v = vec_out; oe2 = vec_oe;
        @(negedge clk);
        inta = 1'b0;
        #1;
    endtask

    task automatic do_reset(input bit prog);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        if (prog) begin
            wr(3'd2, 8'h20);
            wr(3'd3, 8'h70);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe2, oe1;

        // R1 reset state
        do_reset(1'b0);
        check("R1 int_out after reset", int_out, 0);
        check("R1 vec_oe after reset", vec_oe, 0);
        // R9 spurious ack, zero base after reset
        do_ack(v, oe2, oe1);
        check("R1 R9 spurious vector zero base", v, 8'h07);
        check("R9 spurious oe", oe2, 1);
        pulse_irq(16'h0080);
        check("R9 no in-service left by spurious ack", int_out, 1);

        // table walk
        for (int r = 0; r < 9; r++) begin
            do_reset(1'b1);
            wr(3'd0, TBL[r].mm);
            wr(3'd1, TBL[r].sm);
            pulse_irq(TBL[r].irq);
            check($sformatf("R2 row %0d int_out", r), int_out, TBL[r].en);
            if (TBL[r].en) begin
                do_ack(v, oe2, oe1);
                check($sformatf("R7 row %0d vector", r), v, TBL[r].vec);
                check($sformatf("R3 row %0d oe second pulse", r), oe2, 1);
                check($sformatf("R3 row %0d oe first pulse", r), oe1, 0);
            end
        end

        // R4 R5 nesting on master
        do_reset(1'b1);
        pulse_irq(16'h0020);
        do_ack(v, oe2, oe1);
        check("R3 nest vec 5", v, 8'h25);
        check("R3 int low after ack", int_out, 0);
        pulse_irq(16'h0040);
        check("R4 lower waits", int_out, 0);
        pulse_irq(16'h0020);
        check("R4 equal waits", int_out, 0);
        pulse_irq(16'h0002);
        check("R4 higher preempts", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R4 preempt vector", v, 8'h21);
        wr(3'd4, 8'h00);
        check("R5 after eoi int", int_out, 0);
        pulse_irq(16'h0008);
        check("R5 eoi cleared highest in-service", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R4 vec 3", v, 8'h23);
        wr(3'd4, 8'h00);
        wr(3'd4, 8'h00);
        check("R5 pending 5 after two eoi", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R4 vec 5 again", v, 8'h25);
        wr(3'd4, 8'h00);
        do_ack(v, oe2, oe1);
        check("R4 vec 6 last", v, 8'h26);

        // R7 R5 cascade nesting
        do_reset(1'b1);
        pulse_irq(16'h0400);
        do_ack(v, oe2, oe1);
        check("R7 slave vec 2", v, 8'h72);
        pulse_irq(16'h0100);
        check("R4 link busy blocks", int_out, 0);
        wr(3'd4, 8'h00);
        check("R7 slave higher after master eoi", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R7 slave vec 0", v, 8'h70);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h00);
        pulse_irq(16'h0200);
        check("R5 slave eoi cleared idx0", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R5 slave vec 1", v, 8'h71);

        // R6 mask holds request
        do_reset(1'b1);
        wr(3'd0, 8'h10);
        pulse_irq(16'h0010);
        check("R6 masked no int", int_out, 0);
        repeat (5) @(negedge clk);
        #1;
        check("R6 still no int", int_out, 0);
        wr(3'd0, 8'h00);
        check("R6 int on unmask", int_out, 1);
        do_ack(v, oe2, oe1);
        check("R6 latched vector", v, 8'h24);

        // R10 base low bits ignored
        do_reset(1'b1);
        wr(3'd2, 8'hAF);
        pulse_irq(16'h0008);
        do_ack(v, oe2, oe1);
        check("R10 base low bits ignored", v, 8'hAB);
        check("R11 bus released", vec_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule